// File: doc/BRIEF.md
# Loop Program Recorder with Preheader Stamping

This block records a short program for an address-generation sequencer and then plays it back. A host sends one command per cycle. It can append an instruction word, open a loop or close a loop. The block stores no branch offset. When a loop closes, the block marks the instruction just before the body with a loop flag and a count field, and that pair describes the loop. The recorder allows only one open loop at a time. It tracks the open loop with a head register that holds -1 as an "idle" sentinel, not with a stack. A loop is rejected unless it has a preheader instruction in front of it and a body of at least two instructions.

A replay command walks the stored buffer one instruction per cycle. When it reaches a flagged word, the next `count + 1` instructions form the body. The body runs as many times as the trip value carried with the replay command, and a trip value of zero runs it once. Then execution continues after the body. The host can read any stored word at any time through a combinational read-out port.

The recorder has two states. FLAT means no loop is open. OPEN means a loop is open. A successful open moves FLAT to OPEN, and a successful close moves OPEN to FLAT. A rejected command keeps the current state.

The player has three states:
- IDLE: no replay is running.
- LINEAR: straight-line execution.
- BODY: inside a loop body.

The player's transitions are:
- IDLE to LINEAR on a replay of a non-empty buffer.
- LINEAR or BODY to BODY on a flagged word.
- BODY to BODY at the body's end while trips remain, as a jump back to the body start.
- BODY to LINEAR at the body's end on the last pass of an unflagged word.
- Any running state to IDLE after the last stored word.

Top module: `loop_prog_builder`

## Requirements
- R1: After reset the program length is 0, `err_valid` and `exec_valid` are low, and every stored word reads back as flag 0, count 0, data 0.
- R2: An accepted append (op 0) stores `cmd_data` at address `prog_len` with flag 0 and count 0, and increments `prog_len`.
- R3: An append while `prog_len` equals DEPTH reports code 7 (full) and leaves the buffer and length unchanged.
- R4: Opening a loop (op 1) while one is already open reports code 1.
- R5: Opening a loop while `prog_len` is 0 reports code 2, because a preheader must come first. Otherwise the head is set to `prog_len`.
- R6: Closing (op 2) with no open loop reports code 3. Closing when the head is not below `prog_len` reports code 4.
- R7: Closing with a body of exactly one instruction reports code 5. The loop stays open, so a later close can still succeed.
- R8: A successful close sets the flag of word head-1 and writes count = body length - 1 there, keeping its data. It then closes the loop, so a new open is legal.
- R9: Every accepted command is answered one cycle later by a one-cycle `err_valid` with its code (1..7). A successful command leaves `err_valid` low. Any error leaves the buffer unchanged.
- R10: Replay (op 3, trip value in `cmd_data[TW-1:0]`) presents the words in order from address 0, one per cycle, starting the cycle after the command. A flagged word at p with count n is followed by the body p+1..p+1+n, run max(trip,1) times, and then by p+n+2.
- R11: A flag on the last word of a previous loop's body takes effect on that body's final pass.
- R12: While a replay runs, all commands are ignored: no error is reported and the length does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 append, 1 open loop, 2 close loop, 3 replay |
| cmd_data | input | PW | Instruction data (append) or trip value in low TW bits (replay) |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 3 | Reason code (1..7) for the error pulse |
| prog_len | output | AW+1 | Number of stored words |
| rd_addr | input | AW | Read-out address |
| rd_flag | output | 1 | Loop flag of the addressed word |
| rd_count | output | AW | Loop count field of the addressed word |
| rd_data | output | PW | Data of the addressed word |
| exec_valid | output | 1 | Replay is presenting a word |
| exec_addr | output | AW | Address of the presented word |
| exec_data | output | PW | Data of the presented word |

## Verification
The bench targets several corner cases, and each has a visible symptom if the design gets it wrong:
- Open at an empty buffer, and close immediately after opening. A recorder that skipped these would stamp address -1 or a body of length zero.
- A one-word body. A design that closed the loop on this error could not recover with a second close.
- A second loop whose preheader is the last word of the previous body. A player that checked the flag on every pass, or never on the body's end, would show a wrong address order.
- A zero trip value, an append into a full buffer, and commands injected during replay. These show up as a skipped body, a wrapped length, or stray error pulses.

Random command mixes with a fixed seed are compared word by word against a bench model.

// File: rtl/lpb_pkg.sv
package lpb_pkg;

    typedef enum logic [1:0] {
        OP_APPEND = 2'd0,
        OP_BEGIN  = 2'd1,
        OP_END    = 2'd2,
        OP_REPLAY = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_NESTED     = 3'd1,
        ERR_NO_PREHEAD = 3'd2,
        ERR_NO_LOOP    = 3'd3,
        ERR_EMPTY_BODY = 3'd4,
        ERR_SHORT_BODY = 3'd5,
        ERR_RESTAMP    = 3'd6,
        ERR_FULL       = 3'd7
    } err_e;

endpackage

// File: rtl/lpb_store.sv
module lpb_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 4,
    parameter int PW    = 16,
    parameter int NRD   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic                    wr_flag,
    input  logic [CW-1:0]           wr_cnt,
    input  logic [PW-1:0]           wr_pay,
    input  logic [NRD-1:0][AW-1:0]  rd_addr,
    output logic [NRD-1:0]          rd_flag,
    output logic [NRD-1:0][CW-1:0]  rd_cnt,
    output logic [NRD-1:0][PW-1:0]  rd_pay
);
    localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

    logic          flag_q [DEPTH];
    logic [CW-1:0] cnt_q  [DEPTH];
    logic [PW-1:0] pay_q  [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                flag_q[i] <= 1'b0;
                cnt_q[i]  <= '0;
                pay_q[i]  <= '0;
            end
        end else if (wr_en) begin
            flag_q[wr_addr] <= wr_flag;
            cnt_q[wr_addr]  <= wr_cnt;
            pay_q[wr_addr]  <= wr_pay;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        logic hit;
        assign hit        = ({1'b0, rd_addr[g]} < DEPTH_W);
        assign rd_flag[g] = hit ? flag_q[rd_addr[g]] : 1'b0;
        assign rd_cnt[g]  = hit ? cnt_q[rd_addr[g]]  : '0;
        assign rd_pay[g]  = hit ? pay_q[rd_addr[g]]  : '0;
    end

endmodule

// File: rtl/lpb_builder.sv
module lpb_builder
    import lpb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 4,
    parameter int PW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_fire,
    input  op_e           cmd_op,
    input  logic [PW-1:0] cmd_pay,
    input  logic          pre_flag,
    input  logic [PW-1:0] pre_pay,
    output logic [AW-1:0] pre_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          wr_flag,
    output logic [CW-1:0] wr_cnt,
    output logic [PW-1:0] wr_pay,
    output logic [AW:0]   len,
    output logic          err_valid,
    output logic [2:0]    err_code
);
    localparam logic [AW:0]          FULL      = (AW+1)'(DEPTH);
    localparam logic signed [AW+1:0] HEAD_IDLE = -1;

    typedef enum logic {B_FLAT, B_OPEN} bstate_e;

    bstate_e              state_q, state_d;
    logic signed [AW+1:0] head_q, head_d;
    logic [AW:0]          len_q, len_d;
    err_e                 code_d, code_q;
    logic                 errv_q;
    logic [AW:0]          head_u, body_len;

    assign head_u   = head_q[AW:0];
    assign body_len = len_q - head_u;
    assign pre_addr = AW'(head_u - 1'b1);

    // next state, write port and reason code
    always_comb begin
        state_d = state_q;
        head_d  = head_q;
        len_d   = len_q;
        code_d  = ERR_NONE;
        wr_en   = 1'b0;
        wr_addr = len_q[AW-1:0];
        wr_flag = 1'b0;
        wr_cnt  = '0;
        wr_pay  = cmd_pay;
        if (cmd_fire) begin
            unique case (cmd_op)
                OP_APPEND: begin
                    if (len_q == FULL) code_d = ERR_FULL;
                    else begin
                        wr_en = 1'b1;
                        len_d = len_q + 1'b1;
                    end
                end
                OP_BEGIN: begin
                    if (state_q == B_OPEN)   code_d = ERR_NESTED;
                    else if (len_q == '0)    code_d = ERR_NO_PREHEAD;
                    else begin
                        head_d  = $signed({1'b0, len_q});
                        state_d = B_OPEN;
                    end
                end
                OP_END: begin
                    if (state_q == B_FLAT)            code_d = ERR_NO_LOOP;
                    else if (head_u >= len_q)         code_d = ERR_EMPTY_BODY;
                    else if (body_len < (AW+1)'(2))   code_d = ERR_SHORT_BODY;
                    else if (pre_flag)                code_d = ERR_RESTAMP;
                    else begin
                        wr_en   = 1'b1;
                        wr_addr = pre_addr;
                        wr_flag = 1'b1;
                        wr_cnt  = CW'(body_len - 1'b1);
                        wr_pay  = pre_pay;
                        head_d  = HEAD_IDLE;
                        state_d = B_FLAT;
                    end
                end
                OP_REPLAY: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= B_FLAT;
            head_q  <= HEAD_IDLE;
            len_q   <= '0;
            errv_q  <= 1'b0;
            code_q  <= ERR_NONE;
        end else begin
            state_q <= state_d;
            head_q  <= head_d;
            len_q   <= len_d;
            errv_q  <= (code_d != ERR_NONE);
            code_q  <= code_d;
        end
    end

    assign len       = len_q;
    assign err_valid = errv_q;
    assign err_code  = code_q;

    assert_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && cmd_op == OP_APPEND && len_q == FULL)
        |=> (err_valid && err_code == ERR_FULL && $stable(len_q)));

    assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= FULL);

    // an open loop always has a preheader inside the recorded range
    assert_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == B_OPEN) |-> (head_u >= (AW+1)'(1) && head_u <= len_q));

    assert_short_stays_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && cmd_op == OP_END && state_q == B_OPEN && head_u < len_q
         && body_len < (AW+1)'(2)) |=> (state_q == B_OPEN && $stable(head_q)));

endmodule

// File: rtl/lpb_replay.sv
module lpb_replay #(
    parameter int AW = 4,
    parameter int CW = 4,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] trips,
    input  logic [AW:0]   prog_len,
    input  logic          cur_flag,
    input  logic [CW-1:0] cur_cnt,
    output logic          busy,
    output logic [AW-1:0] pc
);
    typedef enum logic [1:0] {R_IDLE, R_LINEAR, R_BODY} rstate_e;

    rstate_e       state_q, state_d;
    logic [AW:0]   pc_q, pc_d, bs_q, bs_d, be_q, be_d, nxt_pc;
    logic [TW-1:0] iter_q, iter_d, trips_q, trips_d;

    assign nxt_pc = pc_q + 1'b1;

    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        bs_d    = bs_q;
        be_d    = be_q;
        iter_d  = iter_q;
        trips_d = trips_q;
        unique case (state_q)
            R_IDLE: begin
                if (start && prog_len != '0) begin
                    state_d = R_LINEAR;
                    pc_d    = '0;
                    trips_d = trips;
                end
            end
            R_LINEAR, R_BODY: begin
                if (state_q == R_BODY && pc_q == be_q && iter_q > TW'(1)) begin
                    pc_d   = bs_q;
                    iter_d = iter_q - 1'b1;
                end else begin
                    if (state_q == R_BODY && pc_q != be_q) begin
                        state_d = R_BODY;
                    end else if (cur_flag) begin
                        bs_d    = nxt_pc;
                        be_d    = nxt_pc + (AW+1)'(cur_cnt);
                        iter_d  = (trips_q == '0) ? TW'(1) : trips_q;
                        state_d = R_BODY;
                    end else begin
                        state_d = R_LINEAR;
                    end
                    pc_d = nxt_pc;
                    if (nxt_pc == prog_len) state_d = R_IDLE;
                end
            end
            default: state_d = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= R_IDLE;
            pc_q    <= '0;
            bs_q    <= '0;
            be_q    <= '0;
            iter_q  <= '0;
            trips_q <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            bs_q    <= bs_d;
            be_q    <= be_d;
            iter_q  <= iter_d;
            trips_q <= trips_d;
        end
    end

    assign busy = (state_q != R_IDLE);
    assign pc   = pc_q[AW-1:0];

    assert_exec_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pc_q < prog_len));

    assert_iter_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_BODY) |-> (iter_q != '0 && be_q < prog_len));

endmodule

// File: rtl/loop_prog_builder.sv
module loop_prog_builder
    import lpb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = 16,
    parameter int TW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [PW-1:0] cmd_data,
    output logic          err_valid,
    output logic [2:0]    err_code,
    output logic [AW:0]   prog_len,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_flag,
    output logic [CW-1:0] rd_count,
    output logic [PW-1:0] rd_data,
    output logic          exec_valid,
    output logic [AW-1:0] exec_addr,
    output logic [PW-1:0] exec_data
);
    localparam int NRD = 3;

    op_e                   op;
    logic                  busy, accept;
    logic                  wr_en, wr_flag;
    logic [AW-1:0]         wr_addr, pre_addr, pc;
    logic [CW-1:0]         wr_cnt;
    logic [PW-1:0]         wr_pay;
    logic [NRD-1:0][AW-1:0] m_addr;
    logic [NRD-1:0]         m_flag;
    logic [NRD-1:0][CW-1:0] m_cnt;
    logic [NRD-1:0][PW-1:0] m_pay;

    assign op     = op_e'(cmd_op);
    assign accept = cmd_valid && !busy;

    assign m_addr[0] = rd_addr;
    assign m_addr[1] = pre_addr;
    assign m_addr[2] = pc;

    lpb_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .PW(PW), .NRD(NRD)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_flag(wr_flag), .wr_cnt(wr_cnt), .wr_pay(wr_pay),
        .rd_addr(m_addr), .rd_flag(m_flag), .rd_cnt(m_cnt), .rd_pay(m_pay)
    );

    lpb_builder #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .PW(PW)) u_build (
        .clk(clk), .rst_n(rst_n),
        .cmd_fire(accept), .cmd_op(op), .cmd_pay(cmd_data),
        .pre_flag(m_flag[1]), .pre_pay(m_pay[1]), .pre_addr(pre_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_flag(wr_flag), .wr_cnt(wr_cnt), .wr_pay(wr_pay),
        .len(prog_len), .err_valid(err_valid), .err_code(err_code)
    );

    lpb_replay #(.AW(AW), .CW(CW), .TW(TW)) u_play (
        .clk(clk), .rst_n(rst_n),
        .start(accept && op == OP_REPLAY), .trips(cmd_data[TW-1:0]),
        .prog_len(prog_len), .cur_flag(m_flag[2]), .cur_cnt(m_cnt[2]),
        .busy(busy), .pc(pc)
    );

    assign rd_flag    = m_flag[0];
    assign rd_count   = m_cnt[0];
    assign rd_data    = m_pay[0];
    assign exec_valid = busy;
    assign exec_addr  = pc;
    assign exec_data  = m_pay[2];

    assert_ignore_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(prog_len) && !err_valid));

endmodule

// File: tb/loop_prog_builder_test.sv
`timescale 1ns/1ps
module loop_prog_builder_test;
    localparam int DEPTH = 16;
    localparam int PW    = 16;
    localparam int TW    = 8;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [PW-1:0] cmd_data = '0;
    logic          err_valid;
    logic [2:0]    err_code;
    logic [AW:0]   prog_len;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_flag;
    logic [AW-1:0] rd_count;
    logic [PW-1:0] rd_data;
    logic          exec_valid;
    logic [AW-1:0] exec_addr;
    logic [PW-1:0] exec_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_len, m_head;
    int m_flag [DEPTH];
    int m_cnt  [DEPTH];
    int m_pay  [DEPTH];
    int trace  [4096];
    int tlen;

    always #2.5 clk = ~clk;

    loop_prog_builder #(.DEPTH(DEPTH), .PW(PW), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .err_valid(err_valid), .err_code(err_code), .prog_len(prog_len),
        .rd_addr(rd_addr), .rd_flag(rd_flag), .rd_count(rd_count), .rd_data(rd_data),
        .exec_valid(exec_valid), .exec_addr(exec_addr), .exec_data(exec_data)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string req_of(int code);
        case (code)
            1: return "R4 nested open";
            2: return "R5 no preheader";
            3, 4: return "R6 close without body";
            5: return "R7 short body";
            7: return "R3 full";
            default: return "R9 code";
        endcase
    endfunction

    function automatic void model_clear();
        m_len = 0;
        m_head = -1;
        for (int i = 0; i < DEPTH; i++) begin
            m_flag[i] = 0; m_cnt[i] = 0; m_pay[i] = 0;
        end
    endfunction

    // expected reason code per the requirements; updates the model
    function automatic int model_cmd(int op, int pay);
        if (op == 0) begin
            if (m_len == DEPTH) return 7;
            m_pay[m_len] = pay & 16'hFFFF; m_flag[m_len] = 0; m_cnt[m_len] = 0;
            m_len++;
            return 0;
        end
        if (op == 1) begin
            if (m_head != -1) return 1;
            if (m_len == 0) return 2;
            m_head = m_len;
            return 0;
        end
        if (m_head == -1) return 3;
        if (m_head >= m_len) return 4;
        if (m_len - m_head < 2) return 5;
        if (m_flag[m_head-1] != 0) return 6;
        m_flag[m_head-1] = 1;
        m_cnt[m_head-1] = m_len - m_head - 1;
        m_head = -1;
        return 0;
    endfunction

    function automatic void build_trace(int trips);
        int pc = 0;
        int n;
        tlen = 0;
        while (pc < m_len) begin
            trace[tlen++] = pc;
            if (m_flag[pc] != 0) begin
                n = (trips == 0) ? 1 : trips;
                for (int it = 0; it < n - 1; it++)
                    for (int a = pc + 1; a <= pc + 1 + m_cnt[pc]; a++) trace[tlen++] = a;
                for (int a = pc + 1; a < pc + 1 + m_cnt[pc]; a++) trace[tlen++] = a;
                pc = pc + 1 + m_cnt[pc];
            end else begin
                pc++;
            end
        end
    endfunction

    task automatic do_cmd(int op, int pay);
        int exp;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_data = PW'(pay);
        exp = model_cmd(op, pay);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 err_valid", int'(err_valid), int'(exp != 0));
        if (exp != 0) chk(req_of(exp), int'(err_code), exp);
        chk(op == 0 ? "R2 prog_len" : "R8 prog_len", int'(prog_len), m_len);
    endtask

    task automatic check_words();
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AW'(a);
            #1;
            chk("R8 word flag", int'(rd_flag), m_flag[a]);
            chk("R8 word count", int'(rd_count), m_cnt[a]);
            chk("R2 word data", int'(rd_data), m_pay[a]);
        end
    endtask

    task automatic do_replay(int trips, bit poke);
        build_trace(trips);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_data = PW'(trips);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < tlen; i++) begin
            chk("R10 exec_valid", int'(exec_valid), 1);
            chk("R10 exec_addr", int'(exec_addr), trace[i]);
            chk("R10 exec_data", int'(exec_data), m_pay[trace[i]]);
            if (poke && tlen > 1 && i == 0) begin
                cmd_valid = 1'b1; cmd_op = 2'd0; cmd_data = 16'hBEEF;
            end
            if (poke && tlen > 1 && i == 1) begin
                cmd_valid = 1'b0;
                chk("R12 no error while busy", int'(err_valid), 0);
            end
            @(negedge clk);
        end
        chk("R10 replay ends", int'(exec_valid), 0);
        if (poke) chk("R12 length kept", int'(prog_len), m_len);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        // R1 reset state
        chk("R1 prog_len", int'(prog_len), 0);
        chk("R1 err_valid", int'(err_valid), 0);
        chk("R1 exec_valid", int'(exec_valid), 0);
        check_words();

        // directed error ladder
        do_cmd(1, 0);            // R5 open at empty
        do_cmd(2, 0);            // R6 close, none open
        do_cmd(0, 16'h1111);     // R2
        do_cmd(1, 0);
        do_cmd(1, 0);            // R4 nested
        do_cmd(2, 0);            // R6 empty body
        do_cmd(0, 16'h2222);
        do_cmd(2, 0);            // R7 short body, loop stays open
        do_cmd(0, 16'h3333);
        do_cmd(2, 0);            // R8 success
        check_words();
        // R11 chained preheader on last body word
        do_cmd(1, 0);
        do_cmd(0, 16'h4444);
        do_cmd(0, 16'h5555);
        do_cmd(2, 0);
        do_cmd(0, 16'h6666);
        check_words();
        do_replay(2, 1'b0);      // R10, R11
        do_replay(0, 1'b1);      // R10 zero trip, R12
        do_replay(3, 1'b1);
        while (m_len < DEPTH) do_cmd(0, int'($urandom & 16'hFFFF));
        do_cmd(0, 16'h7777);     // R3 full
        check_words();
        do_replay(1, 1'b0);

        // constrained random rounds
        for (int r = 0; r < 12; r++) begin
            do_reset();
            for (int k = 0; k < 40; k++) begin
                int sel = int'($urandom % 10);
                do_cmd(sel < 5 ? 0 : (sel < 7 ? 1 : 2), int'($urandom & 16'hFFFF));
            end
            check_words();
            do_replay(int'($urandom % 5), 1'b1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule